// File: doc/BRIEF.md
# Rotating Register Window Controller

This block owns a physical file of 64 registers of 32 bits. Software sees only 16 logical registers, a0 to a15. A 4-bit window base points at one of 16 groups of four physical registers ("quads"). Each logical index is turned into a physical index by adding it to four times the base, wrapping modulo 64. A windowed entry moves the base forward by 1, 2 or 3 quads. A return moves it back by the same amount. In this way a callee gets fresh registers without saving the caller's registers to memory.

A 16-bit ownership vector marks the quads that hold the base of a live frame. A reference to a4–a15 in the current window checks the quads above the base that the reference reaches. An entry checks the quad just above its new base. If one of these quads is still owned by an older frame, the block holds its state and raises an overflow request. The request carries a size class and the quad that must be spilled. The spill handler saves that frame and then acknowledges. On the acknowledge the quad's ownership is cleared, and the requester issues the stalled operation again.

Top module: `winreg_ctrl`

## Requirements
- R1: After reset the window base is 0, the ownership vector is 0x0001 (only quad 0 owned), no overflow request is raised, and every physical register reads 0.
- R2: Logical register i maps to physical register (4*base + i) mod 64. A write commits at the clock edge. Both read ports return the addressed physical register without a clock.
- R3: Operation code 1 (entry) with increment n in 1..3 and no overflow moves the base to (base + n) mod 16 and sets the ownership bit of the new base. Increment 0 changes nothing.
- R4: Operation code 2 (return) with increment n in 1..3 clears the ownership bit of the current base and moves the base to (base − n) mod 16. Increment 0 changes nothing.
- R5: A reference to a0–a3 on any port never raises an overflow, whatever the ownership vector holds.
- R6: An enabled reference to logical quad q (q = index bits [3:2], 1..3) checks quads base+1 through base+q. The lowest owned offset k among all references raises an overflow. ovf_size is k (1 = four registers, 2 = eight, 3 = twelve) and ovf_base is (base + k) mod 16. Both appear with ovf_req one clock after the reference.
- R7: An entry with increment n checks quad (base + n + 1) mod 16. If that quad is owned, an overflow with size code 1 and that quad as ovf_base is raised, and the base does not move.
- R8: In the cycle an overflow is detected, the register write is dropped. While ovf_req is high, writes and operations are ignored and the base and ownership vector hold.
- R9: ovf_ack while ovf_req is high clears the ownership bit of ovf_base and lowers ovf_req at the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_en | input | 1 | Read port A is a real reference (subject to the overflow check) |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | 32 | Data of read port A |
| rd_b_en | input | 1 | Read port B is a real reference |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | 32 | Data of read port B |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | 32 | Write data |
| op_code | input | 2 | 0 none, 1 entry, 2 return |
| op_inc | input | 2 | Rotation increment in quads (0..3) |
| ovf_ack | input | 1 | Spill handler done |
| ovf_req | output | 1 | Window overflow pending |
| ovf_size | output | 2 | Size class: 1, 2 or 3 quads |
| ovf_base | output | 4 | Quad of the frame to spill |
| win_base | output | 4 | Current window base |
| own_vec | output | 16 | Per-quad ownership bits |

## Verification
Translation is tested by writing in one window and reading the same physical register back from another window reached by rotation. This separates a correct base-plus-index sum from one that ignores the base. Rotation is driven around the ring so that the base wraps in both directions, and increment 0 is applied to show that nothing moves. Overflow stimuli include an entry that collides with quad 0 after wrapping. They also include two references whose reach differs (a8 clear, a12 owned), and a reference where two quads are owned, which shows that the lowest offset is reported first. Low-register references are issued while a4 would collide, so the exemption is tested against a quad that is really owned.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    typedef enum logic [1:0] {
        WOP_NONE   = 2'd0,
        WOP_ENTRY  = 2'd1,
        WOP_RETURN = 2'd2
    } win_op_e;

endpackage

// File: rtl/winreg_xlate.sv
module winreg_xlate #(
    parameter int IDX_W  = 4,
    parameter int WB_W   = 4,
    parameter int QW     = 2,
    parameter int PIDX_W = 6
) (
    input  logic [WB_W-1:0]   base,
    input  logic [IDX_W-1:0]  log_idx,
    output logic [PIDX_W-1:0] phys_idx
);
    // Base counts quads; shift it to a register offset and add the field.
    assign phys_idx = PIDX_W'({base, {QW{1'b0}}}) + PIDX_W'(log_idx);
endmodule

// File: rtl/winreg_scan.sv
module winreg_scan #(
    parameter int QUADS  = 16,
    parameter int WB_W   = 4,
    parameter int SPAN_W = 2
) (
    input  logic [QUADS-1:0]  own,
    input  logic [WB_W-1:0]   start,
    input  logic [SPAN_W-1:0] span,
    output logic              hit,
    output logic [SPAN_W-1:0] hit_off
);
    localparam int MAX_OFF = (1 << SPAN_W) - 1;

    // Walk from the far end down so the nearest owned quad wins.
    always_comb begin
        hit     = 1'b0;
        hit_off = '0;
        for (int k = MAX_OFF; k >= 1; k--) begin
            if (k <= int'(span) && own[WB_W'(start + WB_W'(k))]) begin
                hit     = 1'b1;
                hit_off = SPAN_W'(k);
            end
        end
    end
endmodule

// File: rtl/winreg_storage.sv
module winreg_storage #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells_q[i] <= '0;
        end else if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata_a = cells_q[raddr_a];
    assign rdata_b = cells_q[raddr_b];

    // R2: a committed write is visible at its physical slot afterwards
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cells_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl #(
    parameter int DATA_W      = 32,
    parameter int PHYS_REGS   = 64,
    parameter int LOG_REGS    = 16,
    parameter int ENTRY_CHECK = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_a_en,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic              rd_b_en,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        op_code,
    input  logic [1:0]        op_inc,
    input  logic              ovf_ack,
    output logic              ovf_req,
    output logic [1:0]        ovf_size,
    output logic [3:0]        ovf_base,
    output logic [3:0]        win_base,
    output logic [15:0]       own_vec
);
    import winreg_pkg::*;

    localparam int QUAD   = 4;
    localparam int QW     = $clog2(QUAD);
    localparam int IDX_W  = $clog2(LOG_REGS);
    localparam int PIDX_W = $clog2(PHYS_REGS);
    localparam int QUADS  = PHYS_REGS / QUAD;
    localparam int WB_W   = $clog2(QUADS);
    localparam int SPAN_W = IDX_W - QW;
    localparam int NPORT  = 3;

    typedef struct packed {
        logic [WB_W-1:0]   wb;
        logic [QUADS-1:0]  own;
        logic              pend;
        logic [SPAN_W-1:0] size;
        logic [WB_W-1:0]   obase;
    } win_state_t;

    win_state_t st_d, st_q;

    // ---------------- translation of the three register fields ----------
    logic [IDX_W-1:0]  lidx [NPORT];
    logic [PIDX_W-1:0] pidx [NPORT];
    logic              ref_en [NPORT];

    assign lidx[0] = rd_a_idx;
    assign lidx[1] = rd_b_idx;
    assign lidx[2] = wr_idx;
    assign ref_en[0] = rd_a_en;
    assign ref_en[1] = rd_b_en;
    assign ref_en[2] = wr_en;

    for (genvar g = 0; g < NPORT; g++) begin : g_xlate
        winreg_xlate #(
            .IDX_W (IDX_W),
            .WB_W  (WB_W),
            .QW    (QW),
            .PIDX_W(PIDX_W)
        ) u_xlate (
            .base    (st_q.wb),
            .log_idx (lidx[g]),
            .phys_idx(pidx[g])
        );
    end

    // ---------------- reach of the references ---------------------------
    logic [SPAN_W-1:0] ref_span;
    always_comb begin
        ref_span = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (ref_en[p] && lidx[p][IDX_W-1:QW] > ref_span)
                ref_span = lidx[p][IDX_W-1:QW];
        end
    end

    logic              ref_hit, ent_hit;
    logic [SPAN_W-1:0] ref_off, ent_off;
    logic [WB_W-1:0]   new_base;
    logic              is_entry, is_return;
    logic [SPAN_W-1:0] ent_span;

    assign is_entry  = (win_op_e'(op_code) == WOP_ENTRY)  && (op_inc != '0);
    assign is_return = (win_op_e'(op_code) == WOP_RETURN) && (op_inc != '0);
    assign new_base  = st_q.wb + WB_W'(op_inc);
    assign ent_span  = is_entry ? SPAN_W'(ENTRY_CHECK) : '0;

    winreg_scan #(.QUADS(QUADS), .WB_W(WB_W), .SPAN_W(SPAN_W)) u_scan_ref (
        .own    (st_q.own),
        .start  (st_q.wb),
        .span   (ref_span),
        .hit    (ref_hit),
        .hit_off(ref_off)
    );

    winreg_scan #(.QUADS(QUADS), .WB_W(WB_W), .SPAN_W(SPAN_W)) u_scan_ent (
        .own    (st_q.own),
        .start  (new_base),
        .span   (ent_span),
        .hit    (ent_hit),
        .hit_off(ent_off)
    );

    logic raise;
    logic wr_commit;
    assign raise     = !st_q.pend && (ref_hit || ent_hit);
    assign wr_commit = wr_en && !st_q.pend && !raise;

    // ---------------- next state ----------------------------------------
    always_comb begin
        st_d = st_q;
        if (st_q.pend) begin
            if (ovf_ack) begin
                st_d.own[st_q.obase] = 1'b0;
                st_d.pend            = 1'b0;
            end
        end else if (raise) begin
            st_d.pend = 1'b1;
            if (ref_hit) begin
                st_d.size  = ref_off;
                st_d.obase = st_q.wb + WB_W'(ref_off);
            end else begin
                st_d.size  = ent_off;
                st_d.obase = new_base + WB_W'(ent_off);
            end
        end else if (is_entry) begin
            st_d.wb            = new_base;
            st_d.own[new_base] = 1'b1;
        end else if (is_return) begin
            st_d.own[st_q.wb] = 1'b0;
            st_d.wb           = st_q.wb - WB_W'(op_inc);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{wb: '0, own: QUADS'(1), pend: 1'b0, size: '0, obase: '0};
        end else begin
            st_q <= st_d;
        end
    end

    winreg_storage #(.DATA_W(DATA_W), .DEPTH(PHYS_REGS), .AW(PIDX_W)) u_storage (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_commit),
        .waddr  (pidx[2]),
        .wdata  (wr_data),
        .raddr_a(pidx[0]),
        .rdata_a(rd_a_data),
        .raddr_b(pidx[1]),
        .rdata_b(rd_b_data)
    );

    assign ovf_req  = st_q.pend;
    assign ovf_size = st_q.size;
    assign ovf_base = st_q.obase;
    assign win_base = st_q.wb;
    assign own_vec  = st_q.own;

    // ---------------- assertions ----------------------------------------
    // R8: state frozen while the handler has not acknowledged
    assert_hold_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_req && !ovf_ack) |=> ($stable(win_base) && $stable(own_vec)));

    // R9: acknowledge releases the spilled quad and drops the request
    assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_req && ovf_ack) |=> (!ovf_req && !own_vec[$past(ovf_base)]));

    // R6: a pending request always carries a real size class
    assert_size_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_req |-> ovf_size != 2'd0);

    // R7: raising an overflow never rotates the window
    assert_no_rotate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_req) |-> win_base == $past(win_base));

    // R5: references confined to a0-a3 never start an overflow
    assert_low_exempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_req && op_code == 2'd0 &&
         (!rd_a_en || rd_a_idx < 4'd4) &&
         (!rd_b_en || rd_b_idx < 4'd4) &&
         (!wr_en   || wr_idx   < 4'd4)) |=> !ovf_req);

    // R3: an entry that passes its check rotates by the increment
    assert_entry_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_req && !ref_hit && !ent_hit && op_code == 2'd1 && op_inc != 2'd0)
        |=> win_base == $past(win_base + 4'(op_inc)));
endmodule

// File: tb/winreg_ctrl_bench.sv
module winreg_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_a_en = 1'b0, rd_b_en = 1'b0, wr_en = 1'b0, ovf_ack = 1'b0;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  op_code = '0, op_inc = '0;
    logic [31:0] rd_a_data, rd_b_data;
    logic        ovf_req;
    logic [1:0]  ovf_size;
    logic [3:0]  ovf_base, win_base;
    logic [15:0] own_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    winreg_ctrl u_winreg_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .op_code(op_code), .op_inc(op_inc), .ovf_ack(ovf_ack),
        .ovf_req(ovf_req), .ovf_size(ovf_size), .ovf_base(ovf_base),
        .win_base(win_base), .own_vec(own_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_a_en = 0; rd_b_en = 0; wr_en = 0; ovf_ack = 0;
        op_code = 2'd0; op_inc = 2'd0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic peek(input logic [3:0] idx, output logic [31:0] val);
        rd_a_idx = idx;
        #1 val = rd_a_data;
    endtask

    task automatic do_op(input logic [1:0] code, input logic [1:0] inc);
        op_code = code; op_inc = inc;
        step();
    endtask

    task automatic check_win(input string req, input logic [3:0] wb, input logic [15:0] own);
        check(req, 32'(win_base), 32'(wb));
        check(req, 32'(own_vec), 32'(own));
    endtask

    task automatic check_ovf(input string req, input logic [1:0] sz, input logic [3:0] qb);
        check(req, 32'(ovf_req), 32'd1);
        check(req, 32'(ovf_size), 32'(sz));
        check(req, 32'(ovf_base), 32'(qb));
    endtask

    task automatic ack();
        ovf_ack = 1;
        step();
        check("R9 request dropped", 32'(ovf_req), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check_win("R1 reset", 4'd0, 16'h0001);
        check("R1 no request", 32'(ovf_req), 32'd0);
        peek(4'd9, v);
        check("R1 register clear", v, 32'd0);
    endtask

    task automatic t_translate();
        logic [31:0] v;
        wr_en = 1; wr_idx = 4'd5; wr_data = 32'hA1A1_0005;
        step();
        peek(4'd5, v);  check("R2 readback", v, 32'hA1A1_0005);
        do_op(2'd1, 2'd3);
        check_win("R3 entry by 3", 4'd3, 16'h0009);
        wr_en = 1; wr_idx = 4'd2; wr_data = 32'hB2B2_000E;
        step();
        peek(4'd2, v);  check("R2 write in window 3", v, 32'hB2B2_000E);
        peek(4'd5, v);  check("R2 a5 in window 3 is phys 17", v, 32'd0);
        do_op(2'd2, 2'd3);
        check_win("R4 return by 3", 4'd0, 16'h0001);
        peek(4'd5, v);  check("R2 a5 back in window 0", v, 32'hA1A1_0005);
        peek(4'd14, v); check("R2 a14 aliases phys 14", v, 32'hB2B2_000E);
    endtask

    task automatic t_zero_inc();
        do_op(2'd1, 2'd0);
        check_win("R3 entry inc 0", 4'd0, 16'h0001);
        do_op(2'd2, 2'd0);
        check_win("R4 return inc 0", 4'd0, 16'h0001);
    endtask

    task automatic t_entry_overflow();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) do_op(2'd1, 2'd3);
        check_win("R3 four entries", 4'd12, 16'h1249);
        op_code = 2'd1; op_inc = 2'd3;
        wr_en = 1; wr_idx = 4'd4; wr_data = 32'hC3C3_0034;
        step();
        check_ovf("R7 entry collides with quad 0", 2'd1, 4'd0);
        check_win("R7 no rotation", 4'd12, 16'h1249);
        peek(4'd4, v); check("R8 write dropped on raise", v, 32'd0);
        op_code = 2'd1; op_inc = 2'd1;
        wr_en = 1; wr_idx = 4'd6; wr_data = 32'hC4C4_0036;
        step();
        check("R8 still pending", 32'(ovf_req), 32'd1);
        check_win("R8 op ignored while pending", 4'd12, 16'h1249);
        peek(4'd6, v); check("R8 write ignored while pending", v, 32'd0);
        ack();
        check("R9 quad 0 released", 32'(own_vec), 32'h1248);
        do_op(2'd1, 2'd3);
        check_win("R3 retried entry", 4'd15, 16'h9248);
        do_op(2'd1, 2'd1);
        check_win("R3 wrap to base 0", 4'd0, 16'h9249);
    endtask

    task automatic t_reference_overflow();
        rd_b_en = 1; rd_b_idx = 4'd8;
        step();
        check("R6 a8 reaches quads 1-2 only", 32'(ovf_req), 32'd0);
        rd_a_en = 1; rd_a_idx = 4'd12;
        step();
        check_ovf("R6 a12 reaches owned quad 3", 2'd3, 4'd3);
        check_win("R6 window held", 4'd0, 16'h9249);
        ack();
        check("R9 quad 3 released", 32'(own_vec), 32'h9241);
    endtask

    task automatic t_low_exempt_and_priority();
        logic [31:0] v;
        do_op(2'd1, 2'd1);
        do_op(2'd1, 2'd1);
        do_op(2'd1, 2'd1);
        check_win("R3 three single entries", 4'd3, 16'h924F);
        do_op(2'd2, 2'd3);
        check_win("R4 return leaves quads 1,2 owned", 4'd0, 16'h9247);
        rd_a_en = 1; rd_a_idx = 4'd3; rd_b_en = 1; rd_b_idx = 4'd0;
        wr_en = 1; wr_idx = 4'd2; wr_data = 32'hD5D5_0002;
        step();
        check("R5 a0-a3 exempt", 32'(ovf_req), 32'd0);
        peek(4'd2, v); check("R5 low write committed", v, 32'hD5D5_0002);
        rd_a_en = 1; rd_a_idx = 4'd12; rd_b_en = 1; rd_b_idx = 4'd8;
        step();
        check_ovf("R6 lowest offset first", 2'd1, 4'd1);
        ack();
        rd_a_en = 1; rd_a_idx = 4'd12;
        step();
        check_ovf("R6 next offset eight-reg class", 2'd2, 4'd2);
        ack();
        check("R9 quads 1,2 released", 32'(own_vec), 32'h9241);
        do_op(2'd2, 2'd1);
        check_win("R4 return wraps below 0", 4'd15, 16'h9240);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_translate();
        t_zero_inc();
        t_entry_overflow();
        t_reference_overflow();
        t_low_exempt_and_priority();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end
endmodule